// File: doc/BRIEF.md
# Flash Program/Erase Status Byte Generator

This block stands in for the device side of a parallel NOR flash while an internal program or erase algorithm runs. A host that has issued a program or erase command polls the data bus; the block answers each read with a status byte whose bit 7 reports progress and whose bit 5 reports a timeout. When no algorithm is running, reads pass the array data supplied from outside straight through.

Program and erase durations are modelled by cycle counters. An erase lasts a fixed number of cycles per unprotected sector selected. A program whose target sits in a protected sector, or an erase whose selected sectors are all protected, produces only a short status window, after which the block goes back to array reads. An erase can be suspended, and a program can run while it is suspended. A reset command leaves any state and returns the block to array reads.

Addresses are split into sectors by their top `SECT_W` bits. The status byte carries progress in bit 7, timeout in bit 5, and zeros in every other bit.

Top module: `flash_status_gen`

## Requirements
- R1: A program command accepted at a clock edge makes the block report program status to a read strobe sampled at the very next edge.
- R2: While a program runs, a read at the program address returns bit 7 equal to the inverse of bit 7 of the data being programmed, bit 5 equal to the timeout flag, and all other bits 0.
- R3: A program ends after `PROG_CYC` busy cycles. After that, a read at the program address returns the full programmed byte, and other addresses return array data, until the next accepted command or a reset command.
- R4: An erase lasts `SECT_ERASE_CYC` cycles times the number of selected unprotected sectors. While it runs, reads in any selected sector return bit 7 = 0. Once it is done, reads in the erased sectors return 8'hFF and all other addresses return array data.
- R5: A suspend request during an erase freezes its progress. While suspended, reads in a selected sector return 8'h80, and reads elsewhere return array data.
- R6: A program accepted while an erase is suspended follows the R2 rule for status. When it finishes, the block goes back to the suspended erase rather than to array reads.
- R7: A program whose target sector is protected reports program status for `PROT_PROG_CYC` cycles. It then returns to plain array reads with no programmed-byte readback.
- R8: An erase whose selected sectors are all protected reports erase status for `PROT_ERASE_CYC` cycles and then returns to array reads. A partly protected selection erases only its unprotected sectors.
- R9: While a program or erase status is shown, a read at an address that is not valid for that operation returns `DFLT_BYTE`.
- R10: A program or erase still busy after `TIMEOUT_CYC` cycles stops. Bit 5 then reads 1 and bit 7 keeps its in-progress value until a reset command. Protected windows never time out.
- R11: A reset command takes priority over every other input. From the next edge the block is in array-read mode with bit 5 cleared.
- R12: Reset clears the output to 0. The output changes only at an edge where the read strobe is high, taking the value defined for the state and address seen at that edge. In idle, reads return array data.
- R13: The following are ignored: program commands during a program or erase, erase commands in any state other than idle or done, erase commands with an empty sector mask, and suspend requests outside an erase. When program and erase commands arrive together, the program wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progStart | input | 1 | Program command, one-cycle strobe (final write pulse) |
| progAddr | input | ADDR_W | Program target address |
| progData | input | 8 | Byte to program |
| eraseStart | input | 1 | Erase command, one-cycle strobe |
| eraseMask | input | 2**SECT_W | Sectors selected for erase |
| protMask | input | 2**SECT_W | Sector protection flags, latched with each command |
| suspendReq | input | 1 | Erase suspend request |
| resetCmd | input | 1 | Reset command back to array reads |
| rdStrobe | input | 1 | Host read strobe |
| rdAddr | input | ADDR_W | Host read address |
| arrayData | input | 8 | Array contents at rdAddr |
| dataOut | output | 8 | Read data or status byte |

## Verification
Each command is accepted at the edge that samples its strobe. A read strobe sampled at the next edge already sees the new state, and the registered output carries the answer from that same edge until the next strobed read. The bench keeps a behavioural model that advances on every rising edge, and compares the output with it at every falling edge. This places each check half a cycle after the edge that produced the value. Directed reads are placed a known number of cycles into each program, erase, protected window, suspend and timeout, so that literal expected bytes test the durations and the state boundaries.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PROG, ST_PPROT, ST_ERASE, ST_EPROT,
    ST_SUSP, ST_PDONE, ST_EDONE, ST_TOUT
  } fsgStateE;

  typedef enum logic [2:0] {
    VIEW_ARRAY, VIEW_PGM_ST, VIEW_ERS_ST, VIEW_SUSP, VIEW_PGM_DONE, VIEW_ERS_DONE
  } fsgViewE;

  typedef struct packed {
    logic    ldPgm;
    logic    ldErase;
    fsgViewE view;
    logic    dq5;
  } fsgStrobeT;

endpackage

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
  import flash_status_pkg::*;
#(
  parameter int SECT_W         = 3,
  parameter int PROG_CYC       = 12,
  parameter int SECT_ERASE_CYC = 20,
  parameter int PROT_PROG_CYC  = 6,
  parameter int PROT_ERASE_CYC = 25,
  parameter int TIMEOUT_CYC    = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progStart,
  input  logic              eraseStart,
  input  logic              suspendReq,
  input  logic              resetCmd,
  input  logic              tgtProt,
  input  logic              selEmpty,
  input  logic [SECT_W:0]   liveCount,
  output fsgStrobeT         strobe
);

  localparam int NUM_SECT  = 2 ** SECT_W;
  localparam int ERASE_MAX = NUM_SECT * SECT_ERASE_CYC;
  localparam int MAX_A     = (ERASE_MAX > PROG_CYC) ? ERASE_MAX : PROG_CYC;
  localparam int MAX_B     = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
  localparam int MAX_DUR   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W     = $clog2(MAX_DUR + 1);
  localparam int AGE_W     = $clog2(TIMEOUT_CYC + 1);

  fsgStateE             state;
  logic [CNT_W-1:0]     pgmCnt, ersCnt;
  logic [AGE_W-1:0]     pgmAge, ersAge;
  logic                 fromSusp, toutPgm, dq5;
  logic                 pgmAccept, ersAccept;
  logic [CNT_W-1:0]     ersDur;

  always_comb begin
    pgmAccept = progStart &&
                (state inside {ST_IDLE, ST_PDONE, ST_EDONE, ST_SUSP});
    ersAccept = eraseStart && !progStart && !selEmpty &&
                (state inside {ST_IDLE, ST_PDONE, ST_EDONE});
    ersDur    = CNT_W'(liveCount) * CNT_W'(SECT_ERASE_CYC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pgmCnt   <= '0;
      ersCnt   <= '0;
      pgmAge   <= '0;
      ersAge   <= '0;
      fromSusp <= 1'b0;
      toutPgm  <= 1'b0;
      dq5      <= 1'b0;
    end else if (resetCmd) begin
      state    <= ST_IDLE;
      fromSusp <= 1'b0;
      dq5      <= 1'b0;
    end else if (pgmAccept) begin
      fromSusp <= (state == ST_SUSP);
      pgmAge   <= '0;
      if (tgtProt) begin
        state  <= ST_PPROT;
        pgmCnt <= CNT_W'(PROT_PROG_CYC);
      end else begin
        state  <= ST_PROG;
        pgmCnt <= CNT_W'(PROG_CYC);
      end
    end else if (ersAccept) begin
      ersAge <= '0;
      if (liveCount == '0) begin
        state  <= ST_EPROT;
        ersCnt <= CNT_W'(PROT_ERASE_CYC);
      end else begin
        state  <= ST_ERASE;
        ersCnt <= ersDur;
      end
    end else begin
      unique case (state)
        ST_PROG: begin
          if (pgmCnt == CNT_W'(1)) begin
            state <= fromSusp ? ST_SUSP : ST_PDONE;
          end else if (pgmAge == AGE_W'(TIMEOUT_CYC - 1)) begin
            state   <= ST_TOUT;
            toutPgm <= 1'b1;
            dq5     <= 1'b1;
          end else begin
            pgmCnt <= pgmCnt - 1'b1;
            pgmAge <= pgmAge + 1'b1;
          end
        end
        ST_PPROT: begin
          if (pgmCnt == CNT_W'(1)) state <= fromSusp ? ST_SUSP : ST_IDLE;
          else                     pgmCnt <= pgmCnt - 1'b1;
        end
        ST_ERASE: begin
          if (ersCnt == CNT_W'(1)) begin
            state <= ST_EDONE;
          end else if (ersAge == AGE_W'(TIMEOUT_CYC - 1)) begin
            state   <= ST_TOUT;
            toutPgm <= 1'b0;
            dq5     <= 1'b1;
          end else if (suspendReq) begin
            state <= ST_SUSP;
          end else begin
            ersCnt <= ersCnt - 1'b1;
            ersAge <= ersAge + 1'b1;
          end
        end
        ST_EPROT: begin
          if (ersCnt == CNT_W'(1)) state <= ST_IDLE;
          else                     ersCnt <= ersCnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.ldPgm   = pgmAccept && !resetCmd;
    strobe.ldErase = ersAccept && !resetCmd;
    strobe.dq5     = dq5;
    unique case (state)
      ST_PROG, ST_PPROT:   strobe.view = VIEW_PGM_ST;
      ST_ERASE, ST_EPROT:  strobe.view = VIEW_ERS_ST;
      ST_SUSP:             strobe.view = VIEW_SUSP;
      ST_PDONE:            strobe.view = VIEW_PGM_DONE;
      ST_EDONE:            strobe.view = VIEW_ERS_DONE;
      ST_TOUT:             strobe.view = toutPgm ? VIEW_PGM_ST : VIEW_ERS_ST;
      default:             strobe.view = VIEW_ARRAY;
    endcase
  end

  // R1: an accepted program from idle is busy at the next edge
  p_prog_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && progStart && !resetCmd) |=> (state inside {ST_PROG, ST_PPROT}))
    else $error("p_prog_start_r1");

  // R5: suspended erase progress does not move
  p_susp_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP) |=> $stable(ersCnt))
    else $error("p_susp_frozen_r5");

  // R10: timeout is sticky until a reset command
  p_tout_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TOUT && !resetCmd) |=> (state == ST_TOUT && dq5))
    else $error("p_tout_sticky_r10");

  // R10: a protected window never ends in timeout
  p_prot_no_tout_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_PPROT, ST_EPROT}) |=> (state != ST_TOUT))
    else $error("p_prot_no_tout_r10");

  // R11: reset command always lands in array-read mode with bit 5 clear
  p_reset_cmd_r11: assert property (@(posedge clk) disable iff (!rstN)
    resetCmd |=> (state == ST_IDLE && !dq5))
    else $error("p_reset_cmd_r11");

endmodule

// File: rtl/fsg_datapath.sv
module fsg_datapath
  import flash_status_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                SECT_W    = 3,
  parameter logic [BYTE_W-1:0] DFLT_BYTE = 8'hA5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  fsgStrobeT            strobe,
  input  logic [ADDR_W-1:0]    progAddr,
  input  logic [BYTE_W-1:0]    progData,
  input  logic [2**SECT_W-1:0] eraseMask,
  input  logic [2**SECT_W-1:0] protMask,
  input  logic                 rdStrobe,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [BYTE_W-1:0]    arrayData,
  output logic                 tgtProt,
  output logic                 selEmpty,
  output logic [SECT_W:0]      liveCount,
  output logic [BYTE_W-1:0]    dataOut
);

  localparam int NUM_SECT = 2 ** SECT_W;

  logic [ADDR_W-1:0]   pgmAddr;
  logic [BYTE_W-1:0]   pgmData;
  logic [NUM_SECT-1:0] ersSel, ersLive, liveIn;
  logic [SECT_W-1:0]   rdSec;
  logic                pgmHit;
  logic [BYTE_W-1:0]   pgmStatus, ersStatus, readVal;

  // command-side decode
  always_comb begin
    tgtProt   = protMask[progAddr[ADDR_W-1 -: SECT_W]];
    liveIn    = eraseMask & ~protMask;
    selEmpty  = (eraseMask == '0);
    liveCount = '0;
    for (int i = 0; i < NUM_SECT; i++) begin
      liveCount = liveCount + (SECT_W+1)'(liveIn[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgmAddr <= '0;
      pgmData <= '0;
      ersSel  <= '0;
      ersLive <= '0;
    end else begin
      if (strobe.ldPgm) begin
        pgmAddr <= progAddr;
        pgmData <= progData;
      end
      if (strobe.ldErase) begin
        ersSel  <= eraseMask;
        ersLive <= liveIn;
      end
    end
  end

  // read-side selection; status bit 7 = progress, bit 5 = timeout
  always_comb begin
    rdSec     = rdAddr[ADDR_W-1 -: SECT_W];
    pgmHit    = (rdAddr == pgmAddr);
    pgmStatus = {~pgmData[7], 1'b0, strobe.dq5, 5'b0};
    ersStatus = {1'b0, 1'b0, strobe.dq5, 5'b0};
    unique case (strobe.view)
      VIEW_PGM_ST:   readVal = pgmHit ? pgmStatus : DFLT_BYTE;
      VIEW_ERS_ST:   readVal = ersSel[rdSec] ? ersStatus : DFLT_BYTE;
      VIEW_SUSP:     readVal = ersSel[rdSec] ? 8'h80 : arrayData;
      VIEW_PGM_DONE: readVal = pgmHit ? pgmData : arrayData;
      VIEW_ERS_DONE: readVal = ersLive[rdSec] ? 8'hFF : arrayData;
      default:       readVal = arrayData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         dataOut <= '0;
    else if (rdStrobe) dataOut <= readVal;
  end

  // R12: output holds when no read is strobed
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(dataOut))
    else $error("p_hold_r12");

  // R2: program status on a valid address never shows a stale bit 6
  p_status_bit6_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && strobe.view == VIEW_PGM_ST && pgmHit) |=> (dataOut[6] == 1'b0))
    else $error("p_status_bit6_r2");

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int                ADDR_W         = 8,
  parameter int                SECT_W         = 3,
  parameter int                PROG_CYC       = 12,
  parameter int                SECT_ERASE_CYC = 20,
  parameter int                PROT_PROG_CYC  = 6,
  parameter int                PROT_ERASE_CYC = 25,
  parameter int                TIMEOUT_CYC    = 100,
  parameter logic [7:0]        DFLT_BYTE      = 8'hA5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 progStart,
  input  logic [ADDR_W-1:0]    progAddr,
  input  logic [7:0]           progData,
  input  logic                 eraseStart,
  input  logic [2**SECT_W-1:0] eraseMask,
  input  logic [2**SECT_W-1:0] protMask,
  input  logic                 suspendReq,
  input  logic                 resetCmd,
  input  logic                 rdStrobe,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [7:0]           arrayData,
  output logic [7:0]           dataOut
);

  fsgStrobeT         strobe;
  logic              tgtProt, selEmpty;
  logic [SECT_W:0]   liveCount;

  fsg_ctrl #(
    .SECT_W(SECT_W), .PROG_CYC(PROG_CYC), .SECT_ERASE_CYC(SECT_ERASE_CYC),
    .PROT_PROG_CYC(PROT_PROG_CYC), .PROT_ERASE_CYC(PROT_ERASE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .progStart(progStart), .eraseStart(eraseStart),
    .suspendReq(suspendReq), .resetCmd(resetCmd), .tgtProt(tgtProt),
    .selEmpty(selEmpty), .liveCount(liveCount), .strobe(strobe)
  );

  fsg_datapath #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DFLT_BYTE(DFLT_BYTE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .progAddr(progAddr),
    .progData(progData), .eraseMask(eraseMask), .protMask(protMask),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .arrayData(arrayData),
    .tgtProt(tgtProt), .selEmpty(selEmpty), .liveCount(liveCount),
    .dataOut(dataOut)
  );

endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;

  localparam int PROG_CYC = 12, SECT_CYC = 20, PPROT_CYC = 6, EPROT_CYC = 25, TOUT_CYC = 100;
  localparam logic [7:0] DFLT = 8'hA5;

  logic clk = 1'b0, rstN = 1'b0;
  logic progStart = 0, eraseStart = 0, suspendReq = 0, resetCmd = 0, rdStrobe = 0;
  logic [7:0] progAddr = 0, progData = 0, rdAddr = 0, arrayData, dataOut;
  logic [7:0] eraseMask = 0, protMask = 0;
  int errs = 0, checks = 0;
  bit running = 0;

  assign arrayData = rdAddr ^ 8'h3C;
  always #5 clk = ~clk;

  flash_status_gen #(
    .PROG_CYC(PROG_CYC), .SECT_ERASE_CYC(SECT_CYC), .PROT_PROG_CYC(PPROT_CYC),
    .PROT_ERASE_CYC(EPROT_CYC), .TIMEOUT_CYC(TOUT_CYC), .DFLT_BYTE(DFLT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .progStart(progStart), .progAddr(progAddr),
    .progData(progData), .eraseStart(eraseStart), .eraseMask(eraseMask),
    .protMask(protMask), .suspendReq(suspendReq), .resetCmd(resetCmd),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .arrayData(arrayData), .dataOut(dataOut)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // mode: 0 idle 1 program 2 protected program 3 erase 4 protected erase
  //       5 suspended 6 program done 7 erase done 8 timed out
  int mMode = 0, mLeft = 0, mAge = 0, mErsLeft = 0, mErsAge = 0;
  bit mFromSusp = 0, mToutPgm = 0, mTout = 0;
  logic [7:0] mAddr = 0, mData = 0, mSel = 0, mLive = 0, expOut = 0;
  string expTag = "R12";

  function automatic int popc(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  function automatic logic [7:0] modelRead(input logic [7:0] a);
    int sec = a >> 5;
    bit pgmSide = (mMode == 1 || mMode == 2 || (mMode == 8 && mToutPgm));
    bit ersSide = (mMode == 3 || mMode == 4 || (mMode == 8 && !mToutPgm));
    logic [7:0] flag = mTout ? 8'h20 : 8'h00;
    if (pgmSide) return (a == mAddr) ? ((mData[7] ? 8'h00 : 8'h80) | flag) : DFLT;
    if (ersSide) return mSel[sec] ? flag : DFLT;
    if (mMode == 5) return mSel[sec] ? 8'h80 : (a ^ 8'h3C);
    if (mMode == 6) return (a == mAddr) ? mData : (a ^ 8'h3C);
    if (mMode == 7) return mLive[sec] ? 8'hFF : (a ^ 8'h3C);
    return a ^ 8'h3C;
  endfunction

  function automatic string modeTag();
    case (mMode)
      1: return "R2"; 2: return "R7"; 3: return "R4"; 4: return "R8";
      5: return "R5"; 6: return "R3"; 7: return "R4"; 8: return "R10";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mTout = 0; mFromSusp = 0; expOut = 8'h00;
    end else begin
      if (rdStrobe) begin
        expOut = modelRead(rdAddr);
        expTag = modeTag();
      end
      if (resetCmd) begin
        mMode = 0; mTout = 0; mFromSusp = 0;
      end else if (progStart && (mMode == 0 || mMode == 5 || mMode == 6 || mMode == 7)) begin
        mFromSusp = (mMode == 5);
        mAddr = progAddr; mData = progData; mAge = 0;
        if (protMask[progAddr >> 5]) begin mMode = 2; mLeft = PPROT_CYC; end
        else begin mMode = 1; mLeft = PROG_CYC; end
      end else if (eraseStart && eraseMask != 0 && (mMode == 0 || mMode == 6 || mMode == 7)) begin
        mSel = eraseMask; mLive = eraseMask & ~protMask; mErsAge = 0;
        if (mLive == 0) begin mMode = 4; mErsLeft = EPROT_CYC; end
        else begin mMode = 3; mErsLeft = popc(mLive) * SECT_CYC; end
      end else begin
        case (mMode)
          1: if (mLeft == 1) mMode = mFromSusp ? 5 : 6;
             else if (mAge == TOUT_CYC - 1) begin mMode = 8; mToutPgm = 1; mTout = 1; end
             else begin mLeft--; mAge++; end
          2: if (mLeft == 1) mMode = mFromSusp ? 5 : 0; else mLeft--;
          3: if (mErsLeft == 1) mMode = 7;
             else if (mErsAge == TOUT_CYC - 1) begin mMode = 8; mToutPgm = 0; mTout = 1; end
             else if (suspendReq) mMode = 5;
             else begin mErsLeft--; mErsAge++; end
          4: if (mErsLeft == 1) mMode = 0; else mErsLeft--;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, half a cycle after each edge
  always @(negedge clk) if (running) check(dataOut, expOut, expTag);

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doProg(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1 progStart = 1; progAddr = a; progData = d;
    @(posedge clk); #1 progStart = 0;
  endtask

  task automatic doErase(input logic [7:0] sel);
    @(posedge clk); #1 eraseStart = 1; eraseMask = sel;
    @(posedge clk); #1 eraseStart = 0;
  endtask

  task automatic doPulse(input int which);
    @(posedge clk); #1
    if (which == 0) suspendReq = 1; else resetCmd = 1;
    @(posedge clk); #1 suspendReq = 0; resetCmd = 0;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1 rdStrobe = 1; rdAddr = a;
    @(posedge clk); #1 rdStrobe = 0;
    @(negedge clk) check(dataOut, exp, tag);
  endtask

  initial begin : watchdog
    #2000000;
    errs++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    cyc(3);
    check(dataOut, 8'h00, "R12 reset value");
    rstN = 1; running = 1;
    doRead(8'h10, 8'h2C, "R12 idle array read");
    cyc(3);
    check(dataOut, 8'h2C, "R12 hold without strobe");

    // program, bit7 = 0
    doProg(8'h21, 8'h35);
    doRead(8'h21, 8'h80, "R1 R2 complement status");
    doRead(8'h22, DFLT, "R9 non-program address");
    cyc(PROG_CYC + 2);
    doRead(8'h21, 8'h35, "R3 programmed byte readback");
    doRead(8'h40, 8'h7C, "R3 other address array");

    // partly protected erase: sectors 1,2 selected, 2 protected
    protMask = 8'h04;
    doErase(8'h06);
    doRead(8'h50, 8'h00, "R4 erase status in selected sector");
    doRead(8'h80, DFLT, "R9 erase non-selected");
    cyc(SECT_CYC + 2);
    doRead(8'h30, 8'hFF, "R4 erased sector");
    doRead(8'h50, 8'h6C, "R8 protected sector kept");

    // all-protected erase
    protMask = 8'h80;
    doErase(8'h80);
    doRead(8'hE0, 8'h00, "R8 protected erase window");
    cyc(EPROT_CYC + 2);
    doRead(8'hE0, 8'hDC, "R8 back to array");

    // protected program target
    doProg(8'hE5, 8'h80);
    doRead(8'hE5, 8'h00, "R7 protected program status");
    cyc(PPROT_CYC + 2);
    doRead(8'hE5, 8'hD9, "R7 no readback after window");

    // suspend and program in suspend
    protMask = 8'h00;
    doErase(8'h03);
    doRead(8'h05, 8'h00, "R4 erase running");
    doPulse(0);
    doRead(8'h05, 8'h80, "R5 suspended selected sector");
    doRead(8'h70, 8'h4C, "R5 suspended other sector");
    doProg(8'h90, 8'hC3);
    doRead(8'h90, 8'h00, "R6 program in suspend");
    cyc(PROG_CYC + 2);
    doRead(8'h05, 8'h80, "R6 back to suspend");
    doRead(8'h90, 8'hAC, "R6 no readback in suspend");
    doErase(8'h80);
    doRead(8'hE0, 8'hDC, "R13 erase ignored in suspend");
    doPulse(1);
    doRead(8'h05, 8'h39, "R11 reset command to array");

    // ignored commands during program
    doProg(8'h10, 8'h00);
    doProg(8'h11, 8'h80);
    doPulse(0);
    doRead(8'h10, 8'h80, "R13 second program ignored");
    doRead(8'h11, DFLT, "R13 second address not valid");
    cyc(PROG_CYC);
    doRead(8'h10, 8'h00, "R3 readback of first data");
    doErase(8'h00);
    doRead(8'h40, 8'h7C, "R13 empty erase ignored");

    // timeout: six sectors exceed the limit
    doErase(8'h7E);
    cyc(TOUT_CYC + 5);
    doRead(8'h20, 8'h20, "R10 timeout flag");
    cyc(30);
    doRead(8'h20, 8'h20, "R10 timeout sticky");
    doRead(8'h00, DFLT, "R10 invalid address after timeout");
    doPulse(1);
    doRead(8'h20, 8'h1C, "R11 reset after timeout");
    doProg(8'h33, 8'h01);
    doRead(8'h33, 8'h80, "R11 flag cleared");
    cyc(PROG_CYC + 2);

    running = 0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule